// File: doc/BRIEF.md
# Partitioned Bit-Serial Distributed-Arithmetic FIR Dot Product

This block forms the dot product of a fixed set of filter coefficients with a window of input samples. It uses no multiplier. The coefficients are parameters. When the design is elaborated, they are folded into small tables that hold every possible sum of the coefficients in a group of taps. Software or a neighbouring block writes the window one sample at a time through a load strobe with a tap index. A start pulse then begins the computation.

The computation works through the samples one bit weight per clock, starting with bit 0. On each clock, bit k of every sample together forms a table address. The table outputs for all tap groups are added, shifted left by k, and accumulated. When the signed-sample option is selected, the contribution of the top bit weight is subtracted instead of added. After the last bit weight, a one-cycle done pulse marks the result. The result stays unchanged until the next accepted start.

The taps are split into groups of `PT` taps. Each group has its own table of 2^PT entries, so total table storage grows linearly with the tap count. Setting `PT` equal to the tap count gives a single table of 2^NTAPS entries.

Top module: `dabit_fir`

## Requirements
- R1: With unsigned samples, the result equals the sum over taps i of COEFS tap i (signed, CW bits, tap i at bits [i*CW +: CW]) times sample i (unsigned), where sample i is the value last loaded with ld_idx = i.
- R2: With SIGNED_SAMPLES = 1, samples are two's complement: the most significant bit weight counts as -2^(SW-1), and the result equals the signed sum of products.
- R3: The result is two's complement, AW = CW + SW + clog2(NTAPS) bits wide. It is exact for extreme samples (all ones unsigned; all most-negative or all most-positive signed) with no overflow.
- R4: Within a group, table address bit (PT-1-j) selects tap j of the group, so the lowest-numbered tap of a group drives the address MSB. A single table (PT = NTAPS) and a grouped layout give identical results. For 4 taps of coefficient 1 and 4-bit samples 11, 13, 10, 9, the result is 43.
- R5: done is high for exactly one cycle. That cycle directly follows the SW-th rising edge after the edge that samples an accepted start; done is low in every cycle before it.
- R6: Once done has pulsed, result holds its value until the next accepted start, including while new samples are loaded.
- R7: start is accepted only while the block is idle. A start during the computation or during the done cycle neither restarts nor stretches the computation.
- R8: A load strobe while the computation is running is ignored: the buffered window is unchanged. A load at any other time writes ld_data to tap ld_idx.
- R9: Synchronous reset clears all buffered samples and the result to zero, and done is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Sample write strobe |
| ld_idx | input | IW | Tap index written by the strobe |
| ld_data | input | SW | Sample value |
| start | input | 1 | Begin a dot product on the buffered window |
| done | output | 1 | One-cycle pulse when result is valid |
| result | output | AW | Signed dot product, held until next start |

## Verification
The assertions assume that start and the load strobe are sampled on rising edges and that ld_idx names an existing tap. They also assume that reset is held for at least one edge before the first start. The bench drives every input from the falling edge, issues only single-cycle start pulses, and uses tap indices below the tap count. Stray starts and loads during a run are placed deliberately in cycles where the block should ignore them. The expected results come from a direct signed sum of products, computed in the bench, over fixed pseudo-random coefficient sets and sample windows.

// File: rtl/dabit_pkg.sv
package dabit_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        logic clear;
        logic add;
        logic negate;
    } acc_op_t;

    // Address bit that selects tap j of a group of n taps (lowest tap at MSB).
    function automatic int lut_addr_bit(input int j, input int n);
        return n - 1 - j;
    endfunction

endpackage

// File: rtl/dabit_sample_bank.sv
module dabit_sample_bank #(
    parameter int NTAPS = 8,
    parameter int SW    = 8,
    parameter int IW    = 3,
    parameter int BW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [SW-1:0]    wr_data,
    input  logic [BW-1:0]    bit_sel,
    output logic [NTAPS-1:0] slice
);
    logic [SW-1:0] mem [NTAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTAPS; i++) mem[i] <= '0;
        end else if (wr_en && (int'(wr_idx) < NTAPS)) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Sample 0 lands on the slice MSB.
    for (genvar i = 0; i < NTAPS; i++) begin : g_slice
        assign slice[NTAPS-1-i] = mem[i][bit_sel];
    end
endmodule

// File: rtl/dabit_part_lut.sv
module dabit_part_lut #(
    parameter int PT = 2,
    parameter int CW = 8,
    parameter int AW = 19,
    parameter logic [PT*CW-1:0] PCOEF = '0
) (
    input  logic [PT-1:0]        addr,
    output logic signed [AW-1:0] sum
);
    import dabit_pkg::*;

    localparam int ENT = 1 << PT;

    function automatic logic signed [AW-1:0] entry_val(input int a);
        logic signed [AW-1:0] s;
        logic signed [CW-1:0] c;
        s = '0;
        for (int j = 0; j < PT; j++) begin
            c = PCOEF[j*CW +: CW];
            if (((a >> lut_addr_bit(j, PT)) & 1) == 1) s = s + AW'(c);
        end
        return s;
    endfunction

    logic signed [AW-1:0] rom [ENT];

    for (genvar a = 0; a < ENT; a++) begin : g_rom
        assign rom[a] = entry_val(a);
    end

    assign sum = rom[addr];
endmodule

// File: rtl/dabit_shift_acc.sv
module dabit_shift_acc #(
    parameter int AW = 19,
    parameter int BW = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  dabit_pkg::acc_op_t     op,
    input  logic [BW-1:0]          bit_idx,
    input  logic signed [AW-1:0]   term,
    output logic signed [AW-1:0]   acc
);
    logic signed [AW-1:0] weighted;

    assign weighted = term <<< bit_idx;

    always_ff @(posedge clk) begin
        if (rst || op.clear) begin
            acc <= '0;
        end else if (op.add) begin
            if (op.negate) acc <= acc - weighted;
            else           acc <= acc + weighted;
        end
    end
endmodule

// File: rtl/dabit_fir.sv
module dabit_fir #(
    parameter int NTAPS = 8,
    parameter int SW    = 8,
    parameter int CW    = 8,
    parameter int PT    = 2,
    parameter bit SIGNED_SAMPLES = 1'b0,
    parameter logic [NTAPS*CW-1:0] COEFS = 64'h0102030405060708,
    localparam int AW = CW + SW + $clog2(NTAPS),
    localparam int IW = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_valid,
    input  logic [IW-1:0]        ld_idx,
    input  logic [SW-1:0]        ld_data,
    input  logic                 start,
    output logic                 done,
    output logic signed [AW-1:0] result
);
    import dabit_pkg::*;

    localparam int NPART = NTAPS / PT;
    localparam int BW    = (SW > 1) ? $clog2(SW) : 1;
    localparam logic [BW-1:0] LAST = BW'(SW - 1);

    phase_e               phase_q;
    logic [BW-1:0]        bit_q;
    logic                 running;
    acc_op_t              op;
    logic [NTAPS-1:0]     slice;
    logic signed [AW-1:0] psum  [NPART];
    logic signed [AW-1:0] chain [NPART+1];

    assign running = (phase_q == PH_RUN);
    assign done    = (phase_q == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            bit_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q <= PH_RUN;
                    bit_q   <= '0;
                end
                PH_RUN: begin
                    bit_q <= bit_q + BW'(1);
                    if (bit_q == LAST) phase_q <= PH_DONE;
                end
                PH_DONE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        op.clear  = (phase_q == PH_IDLE) && start;
        op.add    = running;
        op.negate = running && SIGNED_SAMPLES && (bit_q == LAST);
    end

    dabit_sample_bank #(.NTAPS(NTAPS), .SW(SW), .IW(IW), .BW(BW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ld_valid && !running),
        .wr_idx  (ld_idx),
        .wr_data (ld_data),
        .bit_sel (bit_q),
        .slice   (slice)
    );

    assign chain[0] = '0;
    for (genvar p = 0; p < NPART; p++) begin : g_part
        dabit_part_lut #(
            .PT(PT), .CW(CW), .AW(AW),
            .PCOEF(COEFS[p*PT*CW +: PT*CW])
        ) u_lut (
            .addr (slice[NTAPS-1-p*PT -: PT]),
            .sum  (psum[p])
        );
        assign chain[p+1] = chain[p] + psum[p];
    end

    dabit_shift_acc #(.AW(AW), .BW(BW)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .bit_idx (bit_q),
        .term    (chain[NPART]),
        .acc     (result)
    );
endmodule

// File: rtl/dabit_fir_checker.sv
module dabit_fir_checker #(
    parameter int SW = 8,
    parameter int AW = 19,
    parameter int BW = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 done,
    input logic signed [AW-1:0] result,
    input logic                 running,
    input logic [BW-1:0]        bit_q
);
    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(running) && $past(bit_q) == BW'(SW - 1)));

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!running && !start) |=> $stable(result));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (running && start && bit_q != BW'(SW - 1)) |=> (running && bit_q == $past(bit_q) + BW'(1)));

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && result == '0));
endmodule

bind dabit_fir dabit_fir_checker #(.SW(SW), .AW(AW), .BW(BW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .done    (done),
    .result  (result),
    .running (running),
    .bit_q   (bit_q)
);

// File: tb/dabit_fir_bench.sv
module dabit_fir_bench;
    localparam int NV = 8;
    localparam int COEF_U [8] = '{17, -5, 42, 127, -128, 9, -33, 76};
    localparam int COEF_S [8] = '{-1, 2, -3, 100, -100, 55, 0, -128};
    localparam logic [63:0] WIN [NV] = '{
        64'h0000000000000000,
        64'h0209330640802C0A,
        64'hFFFFFFFFFFFFFFFF,
        64'h55AA55AA55AA55AA,
        64'h8001807F7F0180FE,
        64'h1234567890ABCDEF,
        64'hC3E1F00F1E3C7896,
        64'h0100000000000080
    };

    function automatic logic [63:0] pack_coefs(input int c [8]);
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = c[i][7:0];
        return v;
    endfunction

    localparam logic [63:0] CU_P = pack_coefs(COEF_U);
    localparam logic [63:0] CS_P = pack_coefs(COEF_S);

    function automatic longint ref_dot(input logic [63:0] w, input int c [8], input bit sgn);
        longint s = 0;
        for (int i = 0; i < 8; i++) begin
            longint x = sgn ? longint'($signed(w[i*8 +: 8])) : longint'(w[i*8 +: 8]);
            s += longint'(c[i]) * x;
        end
        return s;
    endfunction

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       ld8 = 1'b0, st8 = 1'b0;
    logic [2:0] idx8 = '0;
    logic [7:0] dat8 = '0;
    logic       ld4 = 1'b0, st4 = 1'b0;
    logic [1:0] idx4 = '0;
    logic [3:0] dat4 = '0;

    logic done_u, done_s, done_a, done_b;
    logic signed [18:0] res_u, res_s;
    logic signed [7:0]  res_a, res_b;

    dabit_fir #(.NTAPS(8), .SW(8), .CW(8), .PT(2), .SIGNED_SAMPLES(1'b0), .COEFS(CU_P)) u_dabit_fir (
        .clk(clk), .rst(rst), .ld_valid(ld8), .ld_idx(idx8), .ld_data(dat8),
        .start(st8), .done(done_u), .result(res_u));

    dabit_fir #(.NTAPS(8), .SW(8), .CW(8), .PT(2), .SIGNED_SAMPLES(1'b1), .COEFS(CS_P)) u_dabit_fir_signed (
        .clk(clk), .rst(rst), .ld_valid(ld8), .ld_idx(idx8), .ld_data(dat8),
        .start(st8), .done(done_s), .result(res_s));

    dabit_fir #(.NTAPS(4), .SW(4), .CW(2), .PT(4), .COEFS(8'h55)) u_dabit_fir_single (
        .clk(clk), .rst(rst), .ld_valid(ld4), .ld_idx(idx4), .ld_data(dat4),
        .start(st4), .done(done_a), .result(res_a));

    dabit_fir #(.NTAPS(4), .SW(4), .CW(2), .PT(2), .COEFS(8'h55)) u_dabit_fir_split (
        .clk(clk), .rst(rst), .ld_valid(ld4), .ld_idx(idx4), .ld_data(dat4),
        .start(st4), .done(done_b), .result(res_b));

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input longint got, input longint exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic load8(input logic [63:0] w);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ld8 = 1'b1; idx8 = 3'(i); dat8 = w[i*8 +: 8];
        end
        @(negedge clk);
        ld8 = 1'b0;
    endtask

    // Start pulse, stray start/load during the run optional; checks done timing (R5).
    task automatic run8(input bit stray);
        bit early = 1'b0;
        @(negedge clk); st8 = 1'b1;
        @(negedge clk); st8 = 1'b0;
        for (int c = 1; c < 8; c++) begin
            if (stray && c == 3) begin st8 = 1'b1; ld8 = 1'b1; idx8 = 3'd2; dat8 = 8'hE7; end
            else begin st8 = 1'b0; ld8 = 1'b0; end
            @(negedge clk);
            if (done_u || done_s) early = 1'b1;
        end
        st8 = 1'b0; ld8 = 1'b0;
        @(negedge clk);
        check("R5 done low before last slice", longint'(early), 0);
        check("R5 done after SW edges", longint'(done_u & done_s), 1);
        if (stray) st8 = 1'b1;
    endtask

    task automatic after_done8();
        @(negedge clk);
        check("R5 done single cycle", longint'(done_u | done_s), 0);
        st8 = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 done low in reset", longint'(done_u | done_s), 0);
        check("R9 result zero in reset", longint'(res_u), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 result zero after reset", longint'(res_s), 0);

        // Vector table: unsigned (R1) and signed (R2) instances.
        for (int v = 0; v < NV; v++) begin
            load8(WIN[v]);
            run8(1'b0);
            check($sformatf("R1 vec %0d", v), longint'(res_u), ref_dot(WIN[v], COEF_U, 1'b0));
            check($sformatf("R2 vec %0d", v), longint'(res_s), ref_dot(WIN[v], COEF_S, 1'b1));
            after_done8();
        end

        // R3: extremes.
        load8(64'h8080808080808080);
        run8(1'b0);
        check("R3 signed all-min", longint'(res_s), ref_dot(64'h8080808080808080, COEF_S, 1'b1));
        check("R3 unsigned 0x80", longint'(res_u), ref_dot(64'h8080808080808080, COEF_U, 1'b0));
        after_done8();
        load8(64'h7F7F7F7F7F7F7F7F);
        run8(1'b0);
        check("R3 signed all-max", longint'(res_s), ref_dot(64'h7F7F7F7F7F7F7F7F, COEF_S, 1'b1));
        after_done8();

        // R6: result holds while idle loads arrive.
        load8(WIN[5]);
        run8(1'b0);
        after_done8();
        load8(WIN[6]);
        repeat (4) @(negedge clk);
        check("R6 result held", longint'(res_u), ref_dot(WIN[5], COEF_U, 1'b0));

        // R7/R8: stray start and load inside the run, start in done cycle.
        run8(1'b1);
        check("R7 stray start no restart", longint'(res_u), ref_dot(WIN[6], COEF_U, 1'b0));
        after_done8();
        @(negedge clk);
        check("R7 done-cycle start ignored", longint'(done_u), 0);
        run8(1'b0);
        check("R8 load during run ignored", longint'(res_s), ref_dot(WIN[6], COEF_S, 1'b1));
        after_done8();

        // R4: single table vs grouped, 4 taps of 1, samples 11 13 10 9.
        begin
            logic [3:0] s4 [4] = '{4'd11, 4'd13, 4'd10, 4'd9};
            bit early = 1'b0;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk); ld4 = 1'b1; idx4 = 2'(i); dat4 = s4[i];
            end
            @(negedge clk); ld4 = 1'b0; st4 = 1'b1;
            @(negedge clk); st4 = 1'b0;
            for (int c = 1; c < 4; c++) begin
                @(negedge clk);
                if (done_a || done_b) early = 1'b1;
            end
            @(negedge clk);
            check("R5 4-bit done timing", longint'(done_a & done_b & ~early), 1);
            check("R4 single table 43", longint'(res_a), 43);
            check("R4 grouped 43", longint'(res_b), 43);
        end

        // R9: reset clears buffered samples.
        load8(WIN[2]);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        run8(1'b0);
        check("R9 samples cleared", longint'(res_u), 0);
        after_done8();

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule